// File: doc/BRIEF.md
# I2C Slave Address-Match Responder

This block is the target-side half of an I2C unit. It watches the open-drain SCL and SDA lines through synchronisers. It finds START and STOP conditions and shifts in the first byte after every START. It then compares the upper seven bits of that byte with a programmable own address. When the address matches, the block pulls SDA low for the acknowledge clock, records the transfer direction and raises an address event. A zero address with the write bit set is also accepted as a general call, unless software has turned that off.

After the acknowledge clock of the address and of every data byte, the block holds SCL low so that software can service the one-byte data register. Software releases the bus by writing the go bit, which clears itself when the engine takes it. In receive direction, each byte lands in the data register and raises a receive-full event. The acknowledge for the next byte is the one chosen when go was written. In transmit direction, the data register is shifted out MSB first. An acknowledged byte raises a transmit-empty event. A refused byte makes the block let go of SDA and wait for STOP or a new START. A STOP seen while addressed raises a stop event.

Each event stays set until software writes 1 to it, and each has its own interrupt enable. The whole slave path is idle while the unit is set to master drive.

Top module: `i2c_tgt_resp`

## Requirements
- R1: After reset the own-address register (select 3, bits 6:0) reads 0x01, the control (select 0) and status (select 1) registers read 0, and `scl_oe`, `sda_oe` and `irq` are low.
- R2: When the first byte after a START carries the own address, the block drives SDA low during the ninth clock. It also sets status bit 1 (address hit) and copies the byte's R/W bit into status bit 0, where 1 means the master reads.
- R3: A first byte whose address matches neither the own address nor an accepted general call gets no acknowledge. No status bit changes, and the lines stay released until the next START.
- R4: Address 0 with the write bit is acknowledged as a general call and sets status bits 1 and 2. While control bit 2 (general-call off) is 1, the same byte is not acknowledged.
- R5: From the falling SCL edge that ends an acknowledge clock, SCL is held low until control bit 0 (go) is written 1. Go then reads back 0 once the engine has taken it.
- R6: In receive direction, each byte sets status bit 5 (receive full) and is readable from the data register (select 2). The byte is acknowledged when control bit 1 was 0 at the time go was written, and refused when it was 1. A later write to bit 1 does not change the pending choice.
- R7: In transmit direction, the data register is sent MSB first. A master acknowledge sets status bit 4 (transmit empty) and SCL is held. A master refusal leaves bit 4 clear and both lines released.
- R8: A STOP while the block is addressed sets status bit 3. A STOP after a transfer that was not addressed to the block does not.
- R9: While control bit 3 (master drive) is 1, the block neither acknowledges nor reports anything, and it drives neither line.
- R10: Status bits 1 to 5 are cleared only by writing 1 to them on select 1. A 0 written to a bit leaves it unchanged.
- R11: `irq` is high exactly when some status event is set together with its enable: address hit with control bit 4, stop with bit 5, transmit empty with bit 6, receive full with bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the stretch window. An engine that released SCL early would let the master clock bits before software was ready, so the line is sampled with the master's own pull released. It flips the acknowledge choice after go has been written. A design that reads the control bit live instead of latching it would then refuse a byte that should be accepted. On a read, the last byte is refused by the master. An engine that ignored the refusal would still raise transmit empty or keep SDA driven into the STOP, and with SDA held the STOP never forms. Addresses that miss, general calls with the feature off, and traffic in master-drive mode must all leave the status at zero. STOP after those transfers must not flag a stop either.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W) + 1;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_STS  = 2'd1;
   localparam logic [1:0] SEL_DATA = 2'd2;
   localparam logic [1:0] SEL_OWN  = 2'd3;

   localparam int CTL_GO      = 0;
   localparam int CTL_NAK     = 1;
   localparam int CTL_GCOFF   = 2;
   localparam int CTL_MST     = 3;
   localparam int CTL_IE_ADDR = 4;
   localparam int CTL_IE_STOP = 5;
   localparam int CTL_IE_TXE  = 6;
   localparam int CTL_IE_RXF  = 7;

   localparam int STS_DIR  = 0;
   localparam int STS_ADDR = 1;
   localparam int STS_GC   = 2;
   localparam int STS_STOP = 3;
   localparam int STS_TXE  = 4;
   localparam int STS_RXF  = 5;
   localparam int EV_LO    = 1;
   localparam int EV_HI    = 5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_HOLD,
      ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
   } tgt_state_e;

   typedef struct packed {
      logic rxf;
      logic txe;
      logic stop;
      logic gc;
      logic addr;
   } tgt_ev_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout,
   output logic [LINES-1:0] dprev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-1:0], din[l]};
      end
      assign dout[l]  = chain_q[STAGES-1];
      assign dprev[l] = chain_q[STAGES];
   end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic scl_now,
   input  logic scl_was,
   input  logic sda_now,
   input  logic sda_was,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_steady_hi;
   assign scl_steady_hi = scl_now && scl_was;
   assign start_det = scl_steady_hi && sda_was && !sda_now;
   assign stop_det  = scl_steady_hi && !sda_was && sda_now;
   assign scl_rise  = scl_now && !scl_was;
   assign scl_fall  = !scl_now && scl_was;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter bit GC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_off,
   input  logic              mst_mode,
   input  logic              go,
   input  logic              nak_next,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              go_ack,
   output tgt_ev_t           ev,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              dir_rd
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

   tgt_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              sel_q, ack_plan_q, mack_q, dir_q;
   tgt_ev_t           ev_q;
   logic              own_hit, gc_ok;

   assign own_hit = (sh_q[BYTE_W-1:1] == own_addr);

   if (GC_EN) begin : g_gc
      assign gc_ok = (sh_q[BYTE_W-1:1] == '0) && !sh_q[0] && !gc_off;
   end else begin : g_no_gc
      assign gc_ok = 1'b0;
   end

   always_comb begin
      go_ack = (st_q == ST_HOLD) && go && !mst_mode;
      scl_oe = (st_q == ST_HOLD);
      sda_oe = (st_q == ST_ADDR_ACK) ||
               ((st_q == ST_RX_ACK) && ack_plan_q) ||
               ((st_q == ST_TX) && !sh_q[BYTE_W-1]);
   end

   assign ev      = ev_q;
   assign rx_byte = sh_q;
   assign dir_rd  = dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         sh_q       <= '0;
         sel_q      <= 1'b0;
         ack_plan_q <= 1'b0;
         mack_q     <= 1'b0;
         dir_q      <= 1'b0;
         ev_q       <= '0;
      end else begin
         ev_q <= '0;
         if (mst_mode) begin
            st_q  <= ST_IDLE;
            sel_q <= 1'b0;
         end else if (start_det) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
            sel_q <= 1'b0;
         end else if (stop_det) begin
            st_q      <= ST_IDLE;
            ev_q.stop <= sel_q;
            sel_q     <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == FULL_CNT) begin
                     if (own_hit || gc_ok) begin
                        st_q      <= ST_ADDR_ACK;
                        sel_q     <= 1'b1;
                        dir_q     <= sh_q[0];
                        ev_q.addr <= 1'b1;
                        ev_q.gc   <= gc_ok && !own_hit;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: if (scl_fall) st_q <= ST_HOLD;
               ST_HOLD: begin
                  if (go) begin
                     cnt_q <= '0;
                     if (dir_q) begin
                        st_q <= ST_TX;
                        sh_q <= tx_byte;
                     end else begin
                        st_q       <= ST_RX;
                        ack_plan_q <= !nak_next;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == FULL_CNT) begin
                     st_q     <= ST_RX_ACK;
                     ev_q.rxf <= 1'b1;
                  end
               end
               ST_RX_ACK: if (scl_fall) st_q <= ack_plan_q ? ST_HOLD : ST_IDLE;
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt_q == LAST_TX) begin
                        st_q <= ST_TX_ACK;
                     end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack_q <= !sda_lvl;
                  end else if (scl_fall) begin
                     st_q     <= mack_q ? ST_HOLD : ST_IDLE;
                     ev_q.txe <= mack_q;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R7: SDA is only ever changed while the synchronised SCL is low
   assert_sda_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n || mst_mode)
      !$stable(sda_oe) |-> !scl_lvl);

   // R9: master drive keeps both lines released
   assert_master_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mst_mode) && mst_mode) |-> (!scl_oe && !sda_oe));

   // R2/R6/R7: at most one byte-level event per cycle
   assert_event_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_q.addr, ev_q.rxf, ev_q.txe}));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter logic [ADDR_W-1:0] RST_ADDR = 7'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sel,
   input  logic              we,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  tgt_ev_t           ev,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              dir_rd,
   input  logic              go_ack,
   output logic              go,
   output logic              nak_next,
   output logic              gc_off,
   output logic              mst_mode,
   output logic [ADDR_W-1:0] own_addr,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              irq
);
   logic [BYTE_W-1:0] ctrl_q, data_q;
   logic [ADDR_W-1:0] own_q;
   logic [EV_HI:EV_LO] sts_q, ev_vec;
   logic              w_ctrl, w_sts;

   assign w_ctrl = we && (sel == SEL_CTRL);
   assign w_sts  = we && (sel == SEL_STS);
   assign ev_vec = {ev.rxf, ev.txe, ev.stop, ev.gc, ev.addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
         own_q  <= RST_ADDR;
      end else begin
         if (w_ctrl) begin
            ctrl_q[BYTE_W-1:1] <= wdata[BYTE_W-1:1];
            if (wdata[CTL_GO]) ctrl_q[CTL_GO] <= 1'b1;
         end
         if (go_ack) ctrl_q[CTL_GO] <= 1'b0;
         if (we && sel == SEL_OWN) own_q <= wdata[ADDR_W-1:0];
         if (we && sel == SEL_DATA) data_q <= wdata;
         if (ev.rxf) data_q <= rx_byte;
      end
   end

   for (genvar b = EV_LO; b <= EV_HI; b++) begin : g_w1c
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q[b] <= 1'b0;
         else        sts_q[b] <= ev_vec[b] | (sts_q[b] & ~(w_sts & wdata[b]));
      end
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: rdata = ctrl_q;
         SEL_STS:  rdata = {{(BYTE_W-EV_HI-1){1'b0}}, sts_q, dir_rd};
         SEL_DATA: rdata = data_q;
         default:  rdata = {{(BYTE_W-ADDR_W){1'b0}}, own_q};
      endcase
   end

   assign go       = ctrl_q[CTL_GO];
   assign nak_next = ctrl_q[CTL_NAK];
   assign gc_off   = ctrl_q[CTL_GCOFF];
   assign mst_mode = ctrl_q[CTL_MST];
   assign own_addr = own_q;
   assign tx_byte  = data_q;
   assign irq = (sts_q[STS_ADDR] & ctrl_q[CTL_IE_ADDR]) |
                (sts_q[STS_STOP] & ctrl_q[CTL_IE_STOP]) |
                (sts_q[STS_TXE]  & ctrl_q[CTL_IE_TXE])  |
                (sts_q[STS_RXF]  & ctrl_q[CTL_IE_RXF]);

   // R5: go reads back clear after the engine takes it
   assert_go_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go_ack |=> !ctrl_q[CTL_GO]);

   // R10: an address event survives any write that does not carry a 1 in its place
   assert_w1c_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[STS_ADDR] && !(w_sts && wdata[STS_ADDR])) |=> sts_q[STS_ADDR]);
endmodule

// File: rtl/i2c_tgt_resp.sv
module i2c_tgt_resp
   import i2c_tgt_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter bit                GC_EN       = 1'b1,
   parameter logic [ADDR_W-1:0] RST_ADDR    = 7'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_tgt_resp: SYNC_STAGES must be at least 2");
   end
   if (RST_ADDR == '0) begin : g_bad_addr
      $error("i2c_tgt_resp: RST_ADDR must not be the general call address");
   end

   logic [1:0] line_now, line_was;
   logic       start_det, stop_det, scl_rise, scl_fall;
   logic       go, go_ack, nak_next, gc_off, mst_mode, dir_rd;
   logic [ADDR_W-1:0] own_addr;
   logic [BYTE_W-1:0] tx_byte, rx_byte;
   tgt_ev_t    ev;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
      .dout(line_now), .dprev(line_was)
   );

   i2c_tgt_cond u_cond (
      .scl_now(line_now[0]), .scl_was(line_was[0]),
      .sda_now(line_now[1]), .sda_was(line_was[1]),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   i2c_tgt_engine #(.GC_EN(GC_EN)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .scl_lvl(line_now[0]), .sda_lvl(line_now[1]),
      .own_addr(own_addr), .gc_off(gc_off), .mst_mode(mst_mode),
      .go(go), .nak_next(nak_next), .tx_byte(tx_byte),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .go_ack(go_ack),
      .ev(ev), .rx_byte(rx_byte), .dir_rd(dir_rd)
   );

   i2c_tgt_regs #(.RST_ADDR(RST_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .sel(reg_sel), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
      .ev(ev), .rx_byte(rx_byte), .dir_rd(dir_rd), .go_ack(go_ack),
      .go(go), .nak_next(nak_next), .gc_off(gc_off), .mst_mode(mst_mode),
      .own_addr(own_addr), .tx_byte(tx_byte), .irq(irq)
   );

   // R5: once holding SCL, the hold lasts until software writes go
   assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || mst_mode)
      (scl_oe && !go) |=> scl_oe);
endmodule

// File: tb/i2c_tgt_resp_bench.sv
module i2c_tgt_resp_bench;
   localparam int T = 8;
   localparam logic [1:0] S_CTRL = 2'd0, S_STS = 2'd1, S_DATA = 2'd2, S_OWN = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       scl_oe, sda_oe, irq;
   logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic       scl_bus, sda_bus;
   int         n_chk = 0, n_fail = 0;
   logic [6:0] own_sh = 7'h01;
   logic [7:0] dat [4];

   assign scl_bus = !(m_scl_low || scl_oe);
   assign sda_bus = !(m_sda_low || sda_oe);

   always #10 clk = ~clk;

   i2c_tgt_resp u_i2c_tgt_resp (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      summary();
      $finish;
   end

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk); reg_sel = s; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk); reg_sel = s; #1 d = reg_rdata;
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; m_scl_low = 1'b0;
      wait (scl_bus == 1'b1); hw(T);
      m_sda_low = 1'b1; hw(T);
      m_scl_low = 1'b1; hw(T);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; hw(T);
      m_scl_low = 1'b0; wait (scl_bus == 1'b1); hw(T);
      m_sda_low = 1'b0; hw(T);
   endtask

   task automatic m_bit(input logic b);
      m_sda_low = !b; hw(T);
      m_scl_low = 1'b0; wait (scl_bus == 1'b1); hw(T);
      m_scl_low = 1'b1; hw(T);
   endtask

   task automatic m_sample(output logic b);
      m_sda_low = 1'b0; hw(T);
      m_scl_low = 1'b0; wait (scl_bus == 1'b1); hw(T/2);
      b = sda_bus; hw(T/2);
      m_scl_low = 1'b1; hw(T);
   endtask

   task automatic m_wbyte(input logic [7:0] b, output logic ack_n);
      for (int i = 7; i >= 0; i--) m_bit(b[i]);
      m_sample(ack_n);
   endtask

   task automatic m_rbyte(output logic [7:0] b, input logic nak);
      logic x;
      for (int i = 7; i >= 0; i--) begin m_sample(x); b[i] = x; end
      m_bit(nak);
   endtask

   // R5: with the master's pull released, the line must stay low
   task automatic stretch_chk(input string tag);
      m_scl_low = 1'b0; hw(20);
      chk_eq(tag, scl_bus, 0);
      m_scl_low = 1'b1; hw(2);
   endtask

   function automatic bit exp_ack(input logic [6:0] a, input logic rw,
                                  input logic [6:0] own, input logic gcoff, input logic mst);
      if (mst) return 1'b0;
      if (a == own) return 1'b1;
      return (a == 7'h00) && !rw && !gcoff;
   endfunction

   task automatic run_xfer(input logic [6:0] a, input logic rw, input int n,
                           input logic [7:0] cbase, input bit flip_nak);
      logic ack_n; logic [7:0] v, b; bit hit;
      hit = exp_ack(a, rw, own_sh, cbase[2], cbase[3]);
      wr(S_CTRL, cbase);
      wr(S_STS, 8'hff);
      m_start();
      m_wbyte({a, rw}, ack_n);
      chk_eq(hit ? "R2 address acknowledged" : "R3/R4/R9 address refused", ack_n, hit ? 0 : 1);
      rd(S_STS, v);
      if (!hit) begin
         chk_eq("R3/R9 status untouched on miss", v[5:1], 0);
         chk_eq("R9 lines released", {scl_oe, sda_oe}, 0);
         m_stop();
         rd(S_STS, v);
         chk_eq("R8 no stop flag when not addressed", v[3], 0);
         return;
      end
      chk_eq("R2 addr hit and direction", v[1:0], {1'b1, rw});
      chk_eq("R4 general call flag", v[2], (a == 7'h00));
      chk_eq("R11 irq follows address enable", irq, cbase[4]);
      stretch_chk("R5 hold after address ack");
      wr(S_STS, 8'h08);
      rd(S_STS, v);
      chk_eq("R10 zero bits do not clear", v[1], 1);
      wr(S_STS, 8'h06);
      rd(S_STS, v);
      chk_eq("R10 write one clears", v[2:1], 0);
      chk_eq("R11 irq drops after clear", irq, 0);
      for (int i = 0; i < n; i++) begin
         if (!rw) begin
            wr(S_CTRL, cbase | 8'h01 | ((i == n-1) ? 8'h02 : 8'h00));
            if (flip_nak && i == 0 && n > 1) wr(S_CTRL, cbase | 8'h02);
            hw(4);
            rd(S_CTRL, v);
            chk_eq("R5 go self-clears", v[0], 0);
            m_wbyte(dat[i], ack_n);
            chk_eq("R6 acknowledge follows choice at go", ack_n, (i == n-1) ? 1 : 0);
            rd(S_STS, v);
            chk_eq("R6 receive full", v[5], 1);
            rd(S_DATA, v);
            chk_eq("R6 received byte", v, dat[i]);
            wr(S_STS, 8'h20);
            if (i != n-1) stretch_chk("R5 hold after data ack");
         end else begin
            wr(S_DATA, dat[i]);
            wr(S_CTRL, cbase | 8'h01);
            m_rbyte(b, (i == n-1));
            chk_eq("R7 transmitted byte", b, dat[i]);
            hw(4);
            rd(S_STS, v);
            chk_eq("R7 transmit empty only on master ack", v[4], (i != n-1));
            if (i == n-1) chk_eq("R7 lines released after refusal", {scl_oe, sda_oe}, 0);
            else          stretch_chk("R5 hold after sent byte");
            wr(S_STS, 8'h10);
         end
      end
      m_stop();
      rd(S_STS, v);
      chk_eq("R8 stop flag after addressed transfer", v[3], 1);
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'h51A7E));
      hw(3);
      rst_n = 1'b1;
      hw(3);
      rd(S_OWN, v);  chk_eq("R1 own address reset", v, 8'h01);
      rd(S_STS, v);  chk_eq("R1 status reset", v, 0);
      rd(S_CTRL, v); chk_eq("R1 control reset", v, 0);
      chk_eq("R1 outputs reset", {scl_oe, sda_oe, irq}, 0);

      own_sh = 7'h2A; wr(S_OWN, {1'b0, own_sh});
      dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'h81; dat[3] = 8'h7E;
      run_xfer(7'h2A, 1'b0, 3, 8'h10, 1'b1);
      run_xfer(7'h2A, 1'b1, 3, 8'h00, 1'b0);
      run_xfer(7'h2B, 1'b0, 1, 8'h00, 1'b0);
      run_xfer(7'h00, 1'b0, 2, 8'h10, 1'b0);
      run_xfer(7'h00, 1'b0, 1, 8'h04, 1'b0);
      run_xfer(7'h2A, 1'b0, 1, 8'h08, 1'b0);
      wr(S_CTRL, 8'h00);

      for (int k = 0; k < 8; k++) begin
         logic [6:0] a; logic rw; int n; logic [7:0] cb;
         own_sh = 7'($urandom_range(1, 127));
         wr(S_OWN, {1'b0, own_sh});
         a  = ($urandom_range(0, 1) == 0) ? own_sh : 7'($urandom_range(0, 127));
         rw = 1'($urandom_range(0, 1));
         n  = $urandom_range(1, 3);
         cb = {3'b000, 1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)), 2'b00};
         for (int j = 0; j < 4; j++) dat[j] = 8'($urandom_range(0, 255));
         run_xfer(a, rw, n, cb, 1'b0);
      end

      summary();
      $finish;
   end
endmodule